// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Protocol Engine

This block is the slave side of a two-wire serial bus in front of a byte-wide storage array. A fast system clock oversamples the clock line (SCL) and the data line (SDA). Each line passes through a synchronizer and a short glitch filter. From the filtered lines the block detects start and stop conditions and the edges of SCL. After a start it takes an 8-bit device byte. The upper nibble must be the fixed type code `1010`. The next three bits must equal the strap inputs, and the last bit selects the direction: 1 reads and 0 writes. A write then carries two word-address bytes, and every data byte after them is stored at the current address, which then advances. A read streams bytes from the current address. The usual random read is a dummy write that sets the address, then a repeated start with a read device byte. The address wraps from the top of the array to zero.

The slave only pulls SDA low. It never drives it high, so `sda_oe_o` is an open-drain enable. The slave pulls SDA low for acknowledge bits and for zero bits of read data. A write-protect input guards the upper half of the array. While it is high, the device byte and both address bytes are still acknowledged, but a data byte aimed at the upper half is refused. A busy input comes from the separate programming-cycle block. While it is high, the slave does not acknowledge its own device byte. The array holds 2^ADDR_W bytes; the full part uses ADDR_W = 13 (8192 bytes), and the default is smaller to keep elaboration light.

Top module: `eep2w_slave`

## Requirements
- R1: After reset `sda_oe_o` is 0, and bytes clocked on the bus before any start condition are never acknowledged.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. After a stop the slave is idle and acknowledges nothing until the next start.
- R3: The device byte is acknowledged only when bits 7:4 are `1010` and bits 3:1 equal `dev_sel_i`. On a mismatch the byte is not acknowledged, and the slave ignores the bus until the next start.
- R4: The acknowledge for a received byte holds SDA low for the whole high phase of the ninth SCL pulse. `sda_oe_o` changes only while the filtered SCL is low.
- R5: In a write, both word-address bytes are acknowledged. The current address is taken from the low ADDR_W bits of {first byte, second byte}, and higher bits are ignored. Each acknowledged data byte is stored at the current address, and the address then increments.
- R6: In a read, each byte is sent MSB first from the current address, and the address then increments. The increment wraps from 2^ADDR_W-1 to 0, in both reads and writes.
- R7: In a read, a master acknowledge (SDA low on the ninth pulse) makes the slave send the next byte. A master no-acknowledge returns the slave to idle with SDA released.
- R8: A repeated start in the middle of a transfer restarts device-byte matching without a stop.
- R9: With `wp_i` high, a data byte whose address has bit ADDR_W-1 set is not acknowledged, not stored, and does not advance the address. The device byte and the address bytes are still acknowledged, and lower-half writes proceed.
- R10: With `wp_i` low, every address, the upper half included, can be written and read back.
- R11: While `busy_i` is high, a matching device byte is not acknowledged and the slave goes idle.
- R12: A pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| sda_oe_o | output | 1 | Pull SDA low when 1; release when 0 |
| dev_sel_i | input | 3 | Strap value matched against device byte bits 3:1 |
| wp_i | input | 1 | Write protect for the upper half of the array |
| busy_i | input | 1 | Programming cycle in progress; refuse device byte |

## Verification
The bench goes after the address edges first. It writes and reads across the wrap from the last byte to byte zero; a design with a wrong increment would return data from a stale or shifted location there. It sends junk in the unused high bits of the first address byte, which catches an address that is not truncated to the array. Write protect is exercised on both halves and with the protect input both high and low. A refused byte must leave the old contents intact and must not advance the address, so a design that stores the byte, or that skips a location, gives a wrong read-back. Wrong type codes, wrong strap bits, traffic before the first start, traffic after a stop and traffic after a master no-acknowledge must all leave the line released. Short glitches on both lines, placed inside a byte, must not add a bit or fake a start or stop.

// File: rtl/eep2w_pkg.sv
package eep2w_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_RX,
    PH_TX
  } phase_t;

  typedef enum logic [1:0] {
    BK_DEV,
    BK_AHI,
    BK_ALO,
    BK_DATA
  } byte_kind_t;

  localparam logic [3:0] DEV_TYPE_CODE = 4'b1010;

  // device byte layout: [7:4] type code, [3:1] strap bits, [0] 1 = read
  function automatic logic dev_byte_hit(input logic [7:0] b, input logic [2:0] sel);
    return (b[7:4] == DEV_TYPE_CODE) && (b[3:1] == sel);
  endfunction

endpackage

// File: rtl/eep2w_filter.sv
module eep2w_filter #(
  parameter int FILT_LEN = 3,
  parameter bit IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic clean_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          clean_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= {2{IDLE_VAL}};
      cnt_q   <= '0;
      clean_q <= IDLE_VAL;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] == clean_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        clean_q <= sync_q[1];
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign clean_o = clean_q;
endmodule

// File: rtl/eep2w_bus_events.sv
module eep2w_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/eep2w_mem.sv
module eep2w_mem #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] arr_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) arr_q[addr_i] <= wdata_i;
  end

  assign rdata_o = arr_q[addr_i];
endmodule

// File: rtl/eep2w_slave.sv
module eep2w_slave #(
  parameter int ADDR_W   = 11,
  parameter int FILT_LEN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] dev_sel_i,
  input  logic       wp_i,
  input  logic       busy_i
);
  import eep2w_pkg::*;

  localparam int HI_W = ADDR_W - 8;

  function automatic logic [ADDR_W-1:0] addr_inc(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic in_upper_half(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1];
  endfunction

  // filtered lines and bus events
  logic scl_f, sda_f;
  logic scl_rise_evt, scl_fall_evt, start_evt, stop_evt;

  eep2w_filter #(.FILT_LEN(FILT_LEN), .IDLE_VAL(1'b1)) u_scl_filt (
    .clk(clk), .rst_n(rst_n), .raw_i(scl_i), .clean_o(scl_f)
  );
  eep2w_filter #(.FILT_LEN(FILT_LEN), .IDLE_VAL(1'b1)) u_sda_filt (
    .clk(clk), .rst_n(rst_n), .raw_i(sda_i), .clean_o(sda_f)
  );

  eep2w_bus_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_f), .sda_i(sda_f),
    .scl_rise_o(scl_rise_evt), .scl_fall_o(scl_fall_evt),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  // protocol state
  phase_t            phase_q;
  byte_kind_t        kind_q;
  logic [3:0]        bit_cnt_q;
  logic              in_ack_q;
  logic              ack_oe_q;
  logic              tx_en_q;
  logic [7:0]        rx_q;
  logic [7:0]        tx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [HI_W-1:0]   ahi_q;
  logic              rd_q;
  logic              mack_q;

  logic [7:0] mem_rdata;

  // named internal events
  logic byte_done, dev_done, data_done, dev_ok, wp_block, ack_now, mem_we;
  logic phase_idle, addr_msb;
  logic [15:0] full_addr;

  assign byte_done  = scl_fall_evt && (phase_q == PH_RX) && !in_ack_q && (bit_cnt_q == 4'd8);
  assign dev_done   = byte_done && (kind_q == BK_DEV);
  assign data_done  = byte_done && (kind_q == BK_DATA);
  assign dev_ok     = dev_byte_hit(rx_q, dev_sel_i) && !busy_i;
  assign wp_block   = wp_i && in_upper_half(addr_q);
  assign mem_we     = data_done && !wp_block;
  assign phase_idle = (phase_q == PH_IDLE);
  assign addr_msb   = addr_q[ADDR_W-1];
  assign full_addr  = 16'({ahi_q, rx_q});

  always_comb begin
    unique case (kind_q)
      BK_DEV:  ack_now = dev_ok;
      BK_AHI:  ack_now = 1'b1;
      BK_ALO:  ack_now = 1'b1;
      BK_DATA: ack_now = !wp_block;
      default: ack_now = 1'b0;
    endcase
  end

  eep2w_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we_i(mem_we), .addr_i(addr_q), .wdata_i(rx_q), .rdata_o(mem_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      kind_q    <= BK_DEV;
      bit_cnt_q <= '0;
      in_ack_q  <= 1'b0;
      ack_oe_q  <= 1'b0;
      tx_en_q   <= 1'b0;
      rx_q      <= '0;
      tx_q      <= '0;
      addr_q    <= '0;
      ahi_q     <= '0;
      rd_q      <= 1'b0;
      mack_q    <= 1'b0;
    end else if (start_evt) begin
      phase_q   <= PH_RX;
      kind_q    <= BK_DEV;
      bit_cnt_q <= '0;
      in_ack_q  <= 1'b0;
      ack_oe_q  <= 1'b0;
      tx_en_q   <= 1'b0;
    end else if (stop_evt) begin
      phase_q   <= PH_IDLE;
      bit_cnt_q <= '0;
      in_ack_q  <= 1'b0;
      ack_oe_q  <= 1'b0;
      tx_en_q   <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: ;
        PH_RX: begin
          if (scl_rise_evt && !in_ack_q && (bit_cnt_q < 4'd8)) begin
            rx_q      <= {rx_q[6:0], sda_f};
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
          if (byte_done) begin
            if ((kind_q == BK_DEV) && !dev_ok) begin
              phase_q   <= PH_IDLE;
              bit_cnt_q <= '0;
            end else begin
              in_ack_q <= 1'b1;
              ack_oe_q <= ack_now;
              unique case (kind_q)
                BK_DEV:  rd_q   <= rx_q[0];
                BK_AHI:  ahi_q  <= rx_q[HI_W-1:0];
                BK_ALO:  addr_q <= full_addr[ADDR_W-1:0];
                BK_DATA: if (mem_we) addr_q <= addr_inc(addr_q);
                default: ;
              endcase
            end
          end else if (scl_fall_evt && in_ack_q) begin
            in_ack_q  <= 1'b0;
            ack_oe_q  <= 1'b0;
            bit_cnt_q <= '0;
            unique case (kind_q)
              BK_DEV: begin
                if (rd_q) begin
                  phase_q <= PH_TX;
                  tx_q    <= mem_rdata;
                  tx_en_q <= 1'b1;
                  addr_q  <= addr_inc(addr_q);
                end else begin
                  kind_q <= BK_AHI;
                end
              end
              BK_AHI:  kind_q <= BK_ALO;
              BK_ALO:  kind_q <= BK_DATA;
              default: ;
            endcase
          end
        end
        PH_TX: begin
          if (scl_rise_evt) begin
            if (in_ack_q)                mack_q    <= ~sda_f;
            else if (bit_cnt_q < 4'd8)   bit_cnt_q <= bit_cnt_q + 1'b1;
          end
          if (scl_fall_evt) begin
            if (in_ack_q) begin
              in_ack_q  <= 1'b0;
              bit_cnt_q <= '0;
              if (mack_q) begin
                tx_q    <= mem_rdata;
                tx_en_q <= 1'b1;
                addr_q  <= addr_inc(addr_q);
              end else begin
                phase_q <= PH_IDLE;
              end
            end else if (bit_cnt_q == 4'd8) begin
              tx_en_q  <= 1'b0;
              in_ack_q <= 1'b1;
              mack_q   <= 1'b0;
            end else begin
              tx_q <= {tx_q[6:0], 1'b0};
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign sda_oe_o = ack_oe_q | (tx_en_q & ~tx_q[7]);

endmodule

// File: rtl/eep2w_slave_chk.sv
module eep2w_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe_o,
  input logic scl_f,
  input logic start_evt,
  input logic stop_evt,
  input logic dev_done,
  input logic data_done,
  input logic busy_i,
  input logic wp_i,
  input logic addr_msb,
  input logic phase_idle
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    phase_idle |-> !sda_oe_o); // R1

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (phase_idle && !sda_oe_o)); // R2

  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_f); // R4

  AST_RESTART_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (!sda_oe_o && !phase_idle)); // R8

  AST_WP_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (data_done && wp_i && addr_msb) |=> !sda_oe_o); // R9

  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_done && busy_i) |=> (!sda_oe_o && phase_idle)); // R11
endmodule

bind eep2w_slave eep2w_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe_o(sda_oe_o), .scl_f(scl_f),
  .start_evt(start_evt), .stop_evt(stop_evt), .dev_done(dev_done),
  .data_done(data_done), .busy_i(busy_i), .wp_i(wp_i),
  .addr_msb(addr_msb), .phase_idle(phase_idle)
);

// File: tb/eep2w_slave_tb.sv
module eep2w_slave_tb_top;
  localparam int AW    = 11;
  localparam int DEPTH = 1 << AW;
  localparam int Q     = 10;
  localparam logic [2:0] MY_SEL = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic busy = 1'b0;
  logic sda_oe;
  logic sda_line;

  assign sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  eep2w_slave #(.ADDR_W(AW), .FILT_LEN(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .dev_sel_i(MY_SEL), .wp_i(wp), .busy_i(busy)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] ref_mem [DEPTH];
  logic [7:0] wbuf [8];

  function automatic int nxt(input int a);
    return (a + 1) % DEPTH;
  endfunction

  function automatic logic [7:0] dev_byte(input logic [2:0] sel, input logic rd);
    return {4'b1010, sel, rd};
  endfunction

  function automatic logic refused(input int a, input logic wp_on);
    return wp_on && (a >= DEPTH / 2);
  endfunction

  task automatic chk(input logic ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  // sends a byte; ack is 1 only if SDA is low at both ends of the ninth high phase
  task automatic send_byte(input logic [7:0] b, input logic glitch, output logic ack);
    logic a1, a2;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i];
      if (glitch && i == 4) begin
        w(Q / 2); scl_m = 1'b1; w(1); scl_m = 1'b0; w(Q - Q / 2 - 1);
      end else begin
        w(Q);
      end
      scl_m = 1'b1;
      if (glitch && i == 2) begin
        w(Q); sda_m = ~b[i]; w(1); sda_m = b[i]; w(Q - 1);
      end else begin
        w(2 * Q);
      end
      scl_m = 1'b0; w(Q);
    end
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(1);
    a1 = !sda_line;
    w(2 * Q - 2);
    a2 = !sda_line;
    w(1); scl_m = 1'b0; w(Q);
    ack = a1 && a2;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      w(Q); scl_m = 1'b1; w(Q); b = {b[6:0], sda_line}; w(Q); scl_m = 1'b0;
    end
    sda_m = mack ? 1'b0 : 1'b1;
    w(Q); scl_m = 1'b1; w(2 * Q); scl_m = 1'b0; w(Q);
    sda_m = 1'b1;
  endtask

  task automatic send_addr(input int a, input string req);
    logic ack;
    logic [7:0] hi;
    hi = 8'(a >> 8) | (8'($urandom) & ~8'((1 << (AW - 8)) - 1));
    send_byte(hi, 1'b0, ack);
    chk(ack, req, "high address byte ack", ack, 1);
    send_byte(8'(a), 1'b0, ack);
    chk(ack, req, "low address byte ack", ack, 1);
  endtask

  // write wbuf[0..len-1] starting at a; expected acks from the protect rule
  task automatic do_write(input int a, input int len, input logic glitch, input string req);
    logic ack;
    int p;
    p = a;
    bus_start();
    send_byte(dev_byte(MY_SEL, 1'b0), 1'b0, ack);
    chk(ack, "R3", "device byte ack (write)", ack, 1);
    send_addr(a, "R5");
    for (int i = 0; i < len; i++) begin
      send_byte(wbuf[i], glitch, ack);
      chk(ack == !refused(p, wp), req, "data byte ack", ack, !refused(p, wp));
      if (!refused(p, wp)) begin
        ref_mem[p] = wbuf[i];
        p = nxt(p);
      end
    end
    bus_stop();
  endtask

  task automatic do_read(input int a, input int len, input string req);
    logic ack;
    logic [7:0] b;
    int p;
    p = a;
    bus_start();
    send_byte(dev_byte(MY_SEL, 1'b0), 1'b0, ack);
    chk(ack, "R3", "device byte ack (dummy write)", ack, 1);
    send_addr(a, "R5");
    bus_start();
    send_byte(dev_byte(MY_SEL, 1'b1), 1'b0, ack);
    chk(ack, "R8", "device byte ack after repeated start", ack, 1);
    for (int i = 0; i < len; i++) begin
      recv_byte(i < len - 1, b);
      chk(b == ref_mem[p], req, "read data", b, ref_mem[p]);
      p = nxt(p);
    end
    bus_stop();
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic ack;
    logic [7:0] b;
    int a, len;
    void'($urandom(32'h2E5D_0C11));
    w(5);
    rst_n = 1'b1;
    w(5);
    chk(sda_oe == 1'b0, "R1", "oe after reset", sda_oe, 0);

    // bytes with no prior start are ignored
    send_byte(dev_byte(MY_SEL, 1'b0), 1'b0, ack);
    chk(!ack, "R1", "ack before any start", ack, 0);

    // basic write and read-back, low half
    wbuf[0] = 8'h3C; wbuf[1] = 8'hA5; wbuf[2] = 8'h00; wbuf[3] = 8'hFF;
    do_write(12'h123, 4, 1'b0, "R5");
    do_read(12'h123, 4, "R6");

    // after a stop, traffic without start is ignored
    send_byte(dev_byte(MY_SEL, 1'b1), 1'b0, ack);
    chk(!ack, "R2", "ack after stop without start", ack, 0);

    // wrong strap bits, then idle until next start
    bus_start();
    send_byte(dev_byte(MY_SEL ^ 3'b010, 1'b0), 1'b0, ack);
    chk(!ack, "R3", "ack for wrong strap bits", ack, 0);
    send_byte(8'h00, 1'b0, ack);
    chk(!ack, "R3", "ack after mismatch", ack, 0);
    bus_stop();
    // wrong type code
    bus_start();
    send_byte({4'b1011, MY_SEL, 1'b0}, 1'b0, ack);
    chk(!ack, "R3", "ack for wrong type code", ack, 0);
    bus_stop();

    // master NACK ends the read: no drive on further pulses
    bus_start();
    send_byte(dev_byte(MY_SEL, 1'b0), 1'b0, ack);
    send_addr(12'h123, "R5");
    bus_start();
    send_byte(dev_byte(MY_SEL, 1'b1), 1'b0, ack);
    recv_byte(1'b0, b);
    chk(b == ref_mem[12'h123], "R7", "single byte read", b, ref_mem[12'h123]);
    begin
      logic low_seen;
      low_seen = 1'b0;
      for (int i = 0; i < 9; i++) begin
        w(Q); scl_m = 1'b1; w(Q); low_seen |= !sda_line; w(Q); scl_m = 1'b0;
      end
      chk(!low_seen, "R7", "line driven after master nack", low_seen, 0);
    end
    bus_stop();

    // wrap of the address counter
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(DEPTH - 2, 3, 1'b0, "R6");
    do_read(DEPTH - 2, 3, "R6");

    // upper half with protect low, then protect high
    wbuf[0] = 8'h5A; wbuf[1] = 8'hC3;
    do_write(DEPTH - 40, 2, 1'b0, "R10");
    do_read(DEPTH - 40, 2, "R10");
    wp = 1'b1;
    wbuf[0] = 8'h99; wbuf[1] = 8'h66;
    do_write(DEPTH - 40, 2, 1'b0, "R9");
    do_read(DEPTH - 40, 2, "R9");
    wbuf[0] = 8'h7E;
    do_write(12'h040, 1, 1'b0, "R9");
    do_read(12'h040, 1, "R9");
    wp = 1'b0;

    // busy refuses the device byte
    busy = 1'b1;
    bus_start();
    send_byte(dev_byte(MY_SEL, 1'b0), 1'b0, ack);
    chk(!ack, "R11", "ack while busy", ack, 0);
    bus_stop();
    busy = 1'b0;

    // glitches on both lines inside data bytes
    wbuf[0] = 8'hB4; wbuf[1] = 8'h4B;
    do_write(12'h300, 2, 1'b1, "R12");
    do_read(12'h300, 2, "R12");

    // random write/read pairs
    for (int k = 0; k < 10; k++) begin
      a   = int'($urandom % DEPTH);
      len = 1 + int'($urandom % 3);
      for (int i = 0; i < len; i++) wbuf[i] = 8'($urandom);
      do_write(a, len, 1'b0, "R5");
      do_read(a, len, "R6");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule